// File: doc/BRIEF.md
# Branch Target Register Bank

This block holds a small bank of branch target registers that split a branch into two steps: preparation and resolution. A prepare operation names one register and writes into it a target address, a prediction bit and a flag. The prediction bit is the value of a predicate computed earlier by ordinary instructions. The flag says whether that bit is already the real branch direction or only a guess.

A later branch operation names a target register. It is either unconditional or carries a condition predicate that has already been resolved. One cycle after the branch is presented, the block reports four things: whether fetch must be redirected, the fetch target, a hint that the stored direction was certain (so fetch need not treat the path as speculative), and a one-cycle misprediction pulse when a guessed direction turns out to be wrong.

A separate read port shows the stored contents of any register to an instruction prefetcher. Only one branch resolves per cycle. A prepare and a branch that name the same register in the same cycle see the newly written value. The prepare and the compare that produces the condition may happen in either order; the block only samples the condition when the branch arrives.

Top module: `tgt_reg_bank`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, every result output is 0. Every register reads back on the prefetch port with target 0, prediction 0 and known flag 0.
- R2: A prepare with `prep_valid=1` stores `prep_target`, `prep_pred` and `prep_known` into register `prep_idx`. The prefetch port (`pf_idx` selecting) shows the new contents from the clock edge that captures the prepare onward.
- R3: For a conditional branch (`br_uncond=0`), `res_redirect` is 1 exactly when `br_cond` is 1. When `br_cond` is 0 execution falls through and `res_redirect` is 0.
- R4: For an unconditional branch (`br_uncond=1`), `res_redirect` is 1 whatever the value of `br_cond`.
- R5: For every resolved branch, `res_target` carries the stored target of the named register, and `res_pred` carries its stored prediction bit.
- R6: For a conditional branch whose register has known flag 0, `res_mispredict` is 1 exactly when the stored prediction differs from `br_cond`.
- R7: When the named register has known flag 1, `res_no_spec` is 1 and `res_mispredict` is 0, even if the stored bit differs from `br_cond`. When the known flag is 0, `res_no_spec` is 0.
- R8: An unconditional branch never raises `res_mispredict`.
- R9: A prepare and a branch to the same register in the same cycle resolve the branch with the newly prepared target and flags. A prepare to a different register in that cycle does not affect the branch.
- R10: All `res_*` outputs are registered. They are valid in the cycle after the branch is presented, and all of them are 0 in the cycle after a cycle with `br_valid=0`.
- R11: A prepare changes only the register it names. All other registers keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prep_valid | input | 1 | Prepare operation present this cycle |
| prep_idx | input | IDX_W (3) | Register written by the prepare |
| prep_target | input | ADDR_W (32) | Effective target address |
| prep_pred | input | 1 | Value of the predicate operand read for the prepare |
| prep_known | input | 1 | 1: predicate is the real direction, 0: only a guess |
| br_valid | input | 1 | Branch operation present this cycle |
| br_idx | input | IDX_W (3) | Register named by the branch |
| br_uncond | input | 1 | 1: unconditional branch, condition ignored |
| br_cond | input | 1 | Resolved condition predicate of a conditional branch |
| pf_idx | input | IDX_W (3) | Register selected on the prefetch read port |
| pf_target | output | ADDR_W (32) | Stored target of the selected register |
| pf_pred | output | 1 | Stored prediction bit of the selected register |
| pf_known | output | 1 | Stored known flag of the selected register |
| res_valid | output | 1 | A branch resolved in the previous cycle |
| res_redirect | output | 1 | Fetch must move to `res_target` |
| res_target | output | ADDR_W (32) | Target of the resolved branch |
| res_pred | output | 1 | Prediction bit that was stored for the branch |
| res_no_spec | output | 1 | Stored direction was certain; fetch past it is not speculative |
| res_mispredict | output | 1 | Guessed direction differed from the resolved condition |

## Verification
Branch results pass through one register stage. They are due in the cycle after the branch is presented, so the bench drives each branch on a falling edge and reads the results on the next falling edge, after exactly one rising edge. A prepare is visible on the prefetch port as soon as the rising edge that captures it has passed, so readback happens on the following falling edge with no extra wait. Same-cycle prepare/branch collisions are checked at that single-cycle result point, against a bench model that applies the prepare before computing the expected branch result.

// File: rtl/tgt_reg_pkg.sv
package tgt_reg_pkg;

  // Per-register flags stored beside the target address.
  typedef struct packed {
    logic known;   // 1: pred is the real direction
    logic pred;    // stored prediction / direction bit
  } tgt_flags_t;

  // Fetch must move to the target: always for unconditional, else on a true condition.
  function automatic logic f_redirect(input logic uncond, input logic cond);
    return uncond | cond;
  endfunction

  // A guessed conditional direction that disagrees with the resolved condition.
  function automatic logic f_mispredict(input logic uncond, input logic known,
                                        input logic pred,   input logic cond);
    return !uncond && !known && (pred != cond);
  endfunction

endpackage

// File: rtl/tgt_reg_array.sv
module tgt_reg_array
  import tgt_reg_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 32,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_target,
  input  tgt_flags_t        wr_flags,
  input  logic              rd_a_en,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [ADDR_W-1:0] rd_a_target,
  output tgt_flags_t        rd_a_flags,
  output logic              fwd_hit,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [ADDR_W-1:0] rd_b_target,
  output tgt_flags_t        rd_b_flags
);

  logic [ADDR_W-1:0] tgt_q [NUM_REGS];
  tgt_flags_t        flg_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tgt_q[g] <= '0;
        flg_q[g] <= '0;
      end else if (sel) begin
        tgt_q[g] <= wr_target;
        flg_q[g] <= wr_flags;
      end
    end
  end

  // Branch read port: a same-cycle prepare to the same register bypasses the array.
  assign fwd_hit     = wr_en && rd_a_en && (wr_idx == rd_a_idx);
  assign rd_a_target = fwd_hit ? wr_target : tgt_q[rd_a_idx];
  assign rd_a_flags  = fwd_hit ? wr_flags  : flg_q[rd_a_idx];

  // Prefetch read port: stored contents only.
  assign rd_b_target = tgt_q[rd_b_idx];
  assign rd_b_flags  = flg_q[rd_b_idx];

endmodule

// File: rtl/tgt_resolve.sv
module tgt_resolve
  import tgt_reg_pkg::*;
(
  input  logic       br_valid,
  input  logic       br_uncond,
  input  logic       br_cond,
  input  tgt_flags_t flags,
  output logic       redirect,
  output logic       mispredict,
  output logic       no_spec,
  output logic       pred
);

  assign redirect   = br_valid && f_redirect(br_uncond, br_cond);
  assign mispredict = br_valid && f_mispredict(br_uncond, flags.known, flags.pred, br_cond);
  assign no_spec    = br_valid && flags.known;
  assign pred       = br_valid && flags.pred;

endmodule

// File: rtl/tgt_reg_bank.sv
module tgt_reg_bank
  import tgt_reg_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 32,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prep_valid,
  input  logic [IDX_W-1:0]  prep_idx,
  input  logic [ADDR_W-1:0] prep_target,
  input  logic              prep_pred,
  input  logic              prep_known,
  input  logic              br_valid,
  input  logic [IDX_W-1:0]  br_idx,
  input  logic              br_uncond,
  input  logic              br_cond,
  input  logic [IDX_W-1:0]  pf_idx,
  output logic [ADDR_W-1:0] pf_target,
  output logic              pf_pred,
  output logic              pf_known,
  output logic              res_valid,
  output logic              res_redirect,
  output logic [ADDR_W-1:0] res_target,
  output logic              res_pred,
  output logic              res_no_spec,
  output logic              res_mispredict
);

  tgt_flags_t        wr_flags;
  tgt_flags_t        br_flags;
  tgt_flags_t        pf_flags;
  logic [ADDR_W-1:0] br_target;
  logic              fwd_hit;
  logic              nx_redirect;
  logic              nx_mispredict;
  logic              nx_no_spec;
  logic              nx_pred;

  assign wr_flags = '{known: prep_known, pred: prep_pred};

  tgt_reg_array #(
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W),
    .IDX_W    (IDX_W)
  ) u_array (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (prep_valid),
    .wr_idx      (prep_idx),
    .wr_target   (prep_target),
    .wr_flags    (wr_flags),
    .rd_a_en     (br_valid),
    .rd_a_idx    (br_idx),
    .rd_a_target (br_target),
    .rd_a_flags  (br_flags),
    .fwd_hit     (fwd_hit),
    .rd_b_idx    (pf_idx),
    .rd_b_target (pf_target),
    .rd_b_flags  (pf_flags)
  );

  assign pf_pred  = pf_flags.pred;
  assign pf_known = pf_flags.known;

  tgt_resolve u_resolve (
    .br_valid   (br_valid),
    .br_uncond  (br_uncond),
    .br_cond    (br_cond),
    .flags      (br_flags),
    .redirect   (nx_redirect),
    .mispredict (nx_mispredict),
    .no_spec    (nx_no_spec),
    .pred       (nx_pred)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid      <= 1'b0;
      res_redirect   <= 1'b0;
      res_target     <= '0;
      res_pred       <= 1'b0;
      res_no_spec    <= 1'b0;
      res_mispredict <= 1'b0;
    end else begin
      res_valid      <= br_valid;
      res_redirect   <= nx_redirect;
      res_target     <= br_valid ? br_target : '0;
      res_pred       <= nx_pred;
      res_no_spec    <= nx_no_spec;
      res_mispredict <= nx_mispredict;
    end
  end

endmodule

// File: rtl/tgt_reg_bank_chk.sv
module tgt_reg_bank_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              prep_valid,
  input logic [IDX_W-1:0]  prep_idx,
  input logic [ADDR_W-1:0] prep_target,
  input logic              br_valid,
  input logic              br_uncond,
  input logic              br_cond,
  input logic [IDX_W-1:0]  pf_idx,
  input logic [ADDR_W-1:0] pf_target,
  input logic              fwd_hit,
  input logic              res_valid,
  input logic              res_redirect,
  input logic [ADDR_W-1:0] res_target,
  input logic              res_no_spec,
  input logic              res_mispredict
);

  AST_PREP_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    prep_valid && (pf_idx == prep_idx) |=> ($stable(pf_idx) -> (pf_target == $past(prep_target)))); // R2

  AST_COND_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid && !br_uncond |=> res_valid && (res_redirect == $past(br_cond))); // R3

  AST_UNCOND_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid && br_uncond |=> res_valid && res_redirect); // R4

  AST_KNOWN_NO_MISP: assert property (@(posedge clk) disable iff (!rst_n)
    res_no_spec |-> !res_mispredict); // R7

  AST_UNCOND_NO_MISP: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid && br_uncond |=> !res_mispredict); // R8

  AST_FWD_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_hit |=> res_target == $past(prep_target)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |=> !res_valid && !res_redirect && !res_mispredict && !res_no_spec); // R10

endmodule

bind tgt_reg_bank tgt_reg_bank_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/tgt_reg_bank_bench.sv
`timescale 1ns/1ps
module tgt_reg_bank_bench;

  localparam int NREG = 8;
  localparam int AW   = 32;
  localparam int IW   = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          prep_valid = 1'b0;
  logic [IW-1:0] prep_idx = '0;
  logic [AW-1:0] prep_target = '0;
  logic          prep_pred = 1'b0;
  logic          prep_known = 1'b0;
  logic          br_valid = 1'b0;
  logic [IW-1:0] br_idx = '0;
  logic          br_uncond = 1'b0;
  logic          br_cond = 1'b0;
  logic [IW-1:0] pf_idx = '0;
  logic [AW-1:0] pf_target;
  logic          pf_pred, pf_known;
  logic          res_valid, res_redirect, res_pred, res_no_spec, res_mispredict;
  logic [AW-1:0] res_target;

  always #4 clk = ~clk;  // 125 MHz

  tgt_reg_bank #(.NUM_REGS(NREG), .ADDR_W(AW)) u_tgt_reg_bank (.*);

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [AW-1:0] m_tgt   [NREG];
  logic          m_pred  [NREG];
  logic          m_known [NREG];

  task automatic chk(input string tag, input string what, input logic [AW-1:0] got,
                     input logic [AW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic check_pf_all(input string tag);
    for (int i = 0; i < NREG; i++) begin
      pf_idx = IW'(i);
      #1;
      chk(tag, "pf_target", pf_target, m_tgt[i]);
      chk(tag, "pf_pred",   AW'(pf_pred),  AW'(m_pred[i]));
      chk(tag, "pf_known",  AW'(pf_known), AW'(m_known[i]));
    end
  endtask

  task automatic do_prep(input int idx, input logic [AW-1:0] tgt, input logic p, input logic k);
    @(negedge clk);
    prep_valid = 1'b1; prep_idx = IW'(idx); prep_target = tgt; prep_pred = p; prep_known = k;
    @(negedge clk);
    prep_valid = 1'b0;
    m_tgt[idx] = tgt; m_pred[idx] = p; m_known[idx] = k;
  endtask

  // Present a branch (optionally with a same-cycle prepare) and check the results one cycle later.
  task automatic do_branch(input int idx, input logic unc, input logic cnd,
                           input bit with_prep, input int pidx, input logic [AW-1:0] ptgt,
                           input logic pp, input logic pk);
    logic [AW-1:0] e_tgt;
    logic e_pred, e_known, e_redir, e_misp;
    @(negedge clk);
    br_valid = 1'b1; br_idx = IW'(idx); br_uncond = unc; br_cond = cnd;
    if (with_prep) begin
      prep_valid = 1'b1; prep_idx = IW'(pidx); prep_target = ptgt; prep_pred = pp; prep_known = pk;
      if (pidx == idx) begin
        e_tgt = ptgt; e_pred = pp; e_known = pk;
      end else begin
        e_tgt = m_tgt[idx]; e_pred = m_pred[idx]; e_known = m_known[idx];
      end
      m_tgt[pidx] = ptgt; m_pred[pidx] = pp; m_known[pidx] = pk;
    end else begin
      e_tgt = m_tgt[idx]; e_pred = m_pred[idx]; e_known = m_known[idx];
    end
    e_redir = unc ? 1'b1 : cnd;
    e_misp  = (!unc && !e_known && (e_pred != cnd)) ? 1'b1 : 1'b0;
    @(negedge clk);
    br_valid = 1'b0; prep_valid = 1'b0;
    #1;
    chk("R10", "res_valid", AW'(res_valid), 1);
    chk(unc ? "R4" : "R3", "res_redirect", AW'(res_redirect), AW'(e_redir));
    chk(with_prep ? "R9" : "R5", "res_target", res_target, e_tgt);
    chk("R5", "res_pred", AW'(res_pred), AW'(e_pred));
    chk("R7", "res_no_spec", AW'(res_no_spec), AW'(e_known));
    chk(unc ? "R8" : (e_known ? "R7" : "R6"), "res_mispredict", AW'(res_mispredict), AW'(e_misp));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    for (int i = 0; i < NREG; i++) begin
      m_tgt[i] = '0; m_pred[i] = 1'b0; m_known[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "res_valid in reset", AW'(res_valid), 0);
    chk("R1", "res_redirect in reset", AW'(res_redirect), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1", "res_valid after reset", AW'(res_valid), 0);
    chk("R1", "res_mispredict after reset", AW'(res_mispredict), 0);
    chk("R1", "res_target after reset", res_target, 0);
    check_pf_all("R1");
  endtask

  task automatic t_prepare();
    for (int i = 0; i < NREG; i++)
      do_prep(i, 32'h1000_0000 + 32'(i * 32'h44), 1'((i >> 0) & 1), 1'((i >> 1) & 1));
    check_pf_all("R2");
    do_prep(3, 32'hDEAD_BEE0, 1'b1, 1'b0);
    check_pf_all("R11");
  endtask

  task automatic t_cond();
    do_prep(1, 32'h0000_4000, 1'b1, 1'b0);
    do_branch(1, 1'b0, 1'b1, 0, 0, '0, 1'b0, 1'b0);   // guessed taken, taken
    do_branch(1, 1'b0, 1'b0, 0, 0, '0, 1'b0, 1'b0);   // guessed taken, falls through: R6
    do_prep(2, 32'h0000_8000, 1'b0, 1'b0);
    do_branch(2, 1'b0, 1'b1, 0, 0, '0, 1'b0, 1'b0);   // guessed not taken, taken: R6
    do_branch(2, 1'b0, 1'b0, 0, 0, '0, 1'b0, 1'b0);
  endtask

  task automatic t_uncond();
    do_prep(4, 32'hCAFE_0010, 1'b0, 1'b0);
    do_branch(4, 1'b1, 1'b0, 0, 0, '0, 1'b0, 1'b0);   // R4, R8
    do_branch(4, 1'b1, 1'b1, 0, 0, '0, 1'b0, 1'b0);
  endtask

  task automatic t_known();
    do_prep(5, 32'h0BAD_F00C, 1'b1, 1'b1);
    do_branch(5, 1'b0, 1'b1, 0, 0, '0, 1'b0, 1'b0);   // R7 agree
    do_branch(5, 1'b0, 1'b0, 0, 0, '0, 1'b0, 1'b0);   // R7 disagree, still no mispredict
  endtask

  task automatic t_forward();
    do_prep(6, 32'h1111_1110, 1'b1, 1'b0);
    do_branch(6, 1'b0, 1'b0, 1, 6, 32'h2222_2220, 1'b0, 1'b1);  // same register: R9
    do_branch(6, 1'b0, 1'b1, 1, 7, 32'h3333_3330, 1'b1, 1'b0);  // other register
    check_pf_all("R9");
  endtask

  task automatic t_idle();
    do_branch(0, 1'b1, 1'b0, 0, 0, '0, 1'b0, 1'b0);
    @(negedge clk); #1;
    chk("R10", "res_valid idle", AW'(res_valid), 0);
    chk("R10", "res_redirect idle", AW'(res_redirect), 0);
    chk("R10", "res_mispredict idle", AW'(res_mispredict), 0);
    chk("R10", "res_no_spec idle", AW'(res_no_spec), 0);
  endtask

  initial begin
    t_reset();
    t_prepare();
    t_cond();
    t_uncond();
    t_known();
    t_forward();
    t_idle();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule